// File: doc/BRIEF.md
# Tagged Register Stack with Exception Control

This block holds the operand registers of a numeric coprocessor. There are eight 80-bit registers, and each one is split into a sign bit, a 15-bit exponent and a 64-bit significand. Software reaches the registers through a top-of-stack pointer. It can push a value, pop a value, or read or overwrite the register at offset k from the top. Each register carries a 2-bit tag that says whether it is empty or holds a valid, zero or special value. The eight tags are gathered into one 16-bit tag word.

The block turns misuse of the stack into an invalid-operation exception. It also accepts exception reports from an external execution unit. Exceptions are kept as sticky flags. A control word holds one mask bit per flag and a global interrupt-block bit, and together these decide whether the interrupt request is raised. The block does no arithmetic.

One operation is applied per clock. Its effect shows on the registered outputs after that clock edge. The interrupt request is derived without further delay from the registered flags and control word.

Top module: `tagged_reg_stack`

## Requirements
- R1: After reset every tag is empty (tag word 16'hFFFF), the top pointer is 0, all flags are 0, the control word is 16'h003F, rdata_o is 0, rtag_o is 2'b11 and irq_o is low.
- R2: Push (op 3'd1) first decrements the top pointer modulo 8, so 0 wraps to 7. It then stores wdata_i in the new top register, where a later read at offset 0 returns it.
- R3: Tags are encoded 2'b00 valid, 2'b01 zero, 2'b10 special and 2'b11 empty. A stored value is tagged special when special_i is 1. Otherwise it is tagged zero when its exponent and significand (bits 78:0) are all zero, with the sign ignored, and valid in every other case. Bits [2i+1:2i] of tag_word_o hold the tag of physical register i.
- R4: Pop (op 3'd2) puts the top register's value and tag on rdata_o and rtag_o. It then marks that register empty and increments the top pointer modulo 8.
- R5: Read (op 3'd3) puts the value and tag of physical register (top + idx_i) mod 8 on rdata_o and rtag_o. It leaves the tags and the pointer unchanged.
- R6: Write (op 3'd4) replaces physical register (top + idx_i) mod 8 and retags it by the rule of R3, even when that register was empty. The pointer does not change.
- R7: A pop or read of an empty register, or a push while register (top − 1) mod 8 is not empty, sets flag bit 0 (invalid). In that case the pointer, the tags, rdata_o and rtag_o stay unchanged.
- R8: Each cycle, exc_i is ORed into the sticky flags. The bits are 0 invalid, 1 denormal, 2 zero divide, 3 overflow, 4 underflow and 5 precision. Flags stay set until a clear.
- R9: Clear (op 3'd5) zeroes the flags. Any exc_i bits reported in the same cycle are still set.
- R10: Load control (op 3'd6) copies cw_i into ctrl_o. irq_o is high exactly when control bit 7 is 0 and some flag is set whose mask bit (control bits 5:0) is 0.
- R11: status_o carries the flags in bits 5:0 and the top pointer in bits 10:8. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 read, 4 write, 5 clear flags, 6 load control, 7 none |
| idx_i | input | 3 | Register offset from the top for read and write |
| wdata_i | input | 80 | Value for push and write (sign, exponent, significand) |
| special_i | input | 1 | Tag the stored value as special |
| exc_i | input | 6 | Exception reports from the execution unit |
| cw_i | input | 16 | Control word for load control |
| rdata_o | output | 80 | Value from the last successful pop or read |
| rtag_o | output | 2 | Tag of that value |
| tag_word_o | output | 16 | Packed tags of all eight registers |
| status_o | output | 16 | Flags and top pointer |
| ctrl_o | output | 16 | Control word |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong top pointer shows up in status bits 10:8 on the cycle right after the operation that moved it. It shows up again one operation later, when a relative read or pop returns data from the wrong register. A tag that is lost or misclassified changes tag_word_o at once. Later it shows as a spurious or missing invalid flag when the register is next read, popped or pushed over. Errors in flag stickiness or in masking appear on irq_o in the cycle after the report, so the vector sequence moves the control word through masked, blocked and open settings while flags are pending.

// File: rtl/tagstk_pkg.sv
package tagstk_pkg;

    // Register tag encoding
    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    // Operation codes
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_CLEAR  = 3'd5,
        OP_LOADCW = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    // Exception flag positions: the mask bit with the same index guards each flag
    localparam int EXC_INVALID   = 0;
    localparam int EXC_DENORMAL  = 1;
    localparam int EXC_ZERODIV   = 2;
    localparam int EXC_OVERFLOW  = 3;
    localparam int EXC_UNDERFLOW = 4;
    localparam int EXC_PRECISION = 5;

    // Control word bit that blocks every interrupt when set
    localparam int CW_IRQ_BLOCK = 7;

endpackage

// File: rtl/tagstk_classify.sv
module tagstk_classify
    import tagstk_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W+SIG_W:0] value_i,
    input  logic                 special_i,
    output tag_e                 tag_o
);

    localparam int MAG_W = EXP_W + SIG_W;

    always_comb begin
        if (special_i) begin
            tag_o = TAG_SPECIAL;
        end else if (value_i[MAG_W-1:0] == '0) begin
            tag_o = TAG_ZERO;     // sign bit does not matter
        end else begin
            tag_o = TAG_VALID;
        end
    end

endmodule

// File: rtl/tagstk_regs.sv
module tagstk_regs
    import tagstk_pkg::*;
#(
    parameter int DEPTH  = 8,     // power of two, pointer wraps naturally
    parameter int DATA_W = 80
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  op_e                        op_i,
    input  logic [$clog2(DEPTH)-1:0]   idx_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  tag_e                       wtag_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [1:0]                 rtag_o,
    output logic [2*DEPTH-1:0]         tags_o,
    output logic [$clog2(DEPTH)-1:0]   top_o,
    output logic                       fault_o
);

    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] regs;
        logic [DEPTH-1:0][1:0]        tags;
        logic [PTR_W-1:0]             top;
        logic [DATA_W-1:0]            rdata;
        logic [1:0]                   rtag;
    } state_t;

    state_t           st_q, st_d;
    logic [PTR_W-1:0] below_ptr;
    logic [PTR_W-1:0] rel_ptr;
    logic             fault_d;

    assign below_ptr = st_q.top - PTR_W'(1);
    assign rel_ptr   = st_q.top + idx_i;

    always_comb begin
        st_d    = st_q;
        fault_d = 1'b0;
        case (op_i)
            OP_PUSH: begin
                if (st_q.tags[below_ptr] != TAG_EMPTY) begin
                    fault_d = 1'b1;                 // stack full
                end else begin
                    st_d.top             = below_ptr;
                    st_d.regs[below_ptr] = wdata_i;
                    st_d.tags[below_ptr] = wtag_i;
                end
            end
            OP_POP: begin
                if (st_q.tags[st_q.top] == TAG_EMPTY) begin
                    fault_d = 1'b1;                 // stack empty
                end else begin
                    st_d.rdata          = st_q.regs[st_q.top];
                    st_d.rtag           = st_q.tags[st_q.top];
                    st_d.tags[st_q.top] = TAG_EMPTY;
                    st_d.top            = st_q.top + PTR_W'(1);
                end
            end
            OP_READ: begin
                if (st_q.tags[rel_ptr] == TAG_EMPTY) begin
                    fault_d = 1'b1;
                end else begin
                    st_d.rdata = st_q.regs[rel_ptr];
                    st_d.rtag  = st_q.tags[rel_ptr];
                end
            end
            OP_WRITE: begin
                st_d.regs[rel_ptr] = wdata_i;
                st_d.tags[rel_ptr] = wtag_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tags <= '1;
            st_q.rtag <= TAG_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tagword
        assign tags_o[2*gi +: 2] = st_q.tags[gi];
    end

    assign rdata_o = st_q.rdata;
    assign rtag_o  = st_q.rtag;
    assign top_o   = st_q.top;
    assign fault_o = fault_d;

    // R7: a faulting operation leaves the pointer in place
    p_fault_keeps_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> $stable(st_q.top));

    // R2: an accepted push moves the pointer down by one, wrapping
    p_push_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PUSH && !fault_o) |=> (st_q.top == $past(st_q.top) - PTR_W'(1)));

    // R4: after an accepted pop the register just below the new top is empty
    p_pop_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_POP && !fault_o) |=> (st_q.tags[st_q.top - PTR_W'(1)] == TAG_EMPTY));

    // R5: a read never alters pointer or tags
    p_read_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_READ) |=> ($stable(st_q.tags) && $stable(st_q.top)));

endmodule

// File: rtl/tagstk_excp.sv
module tagstk_excp
    import tagstk_pkg::*;
#(
    parameter int              EXC_N    = 6,
    parameter int              CW_W     = 16,
    parameter logic [CW_W-1:0] CW_RESET = 16'h003F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             load_i,
    input  logic [CW_W-1:0]  cw_i,
    input  logic             fault_i,
    input  logic [EXC_N-1:0] ext_i,
    output logic [EXC_N-1:0] flags_o,
    output logic [CW_W-1:0]  ctrl_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [EXC_N-1:0] flags;
        logic [CW_W-1:0]  ctrl;
    } state_t;

    state_t           st_q, st_d;
    logic [EXC_N-1:0] fault_vec;

    always_comb begin
        fault_vec              = '0;
        fault_vec[EXC_INVALID] = fault_i;
        st_d       = st_q;
        st_d.flags = (clear_i ? '0 : st_q.flags) | ext_i | fault_vec;
        if (load_i) begin
            st_d.ctrl = cw_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.ctrl  <= CW_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign ctrl_o  = st_q.ctrl;
    assign irq_o   = !st_q.ctrl[CW_IRQ_BLOCK] && |(st_q.flags & ~st_q.ctrl[EXC_N-1:0]);

    // R8: without a clear, no flag is ever lost
    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    // R7: a stack fault is visible as invalid on the next cycle
    p_fault_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> st_q.flags[EXC_INVALID]);

    // R9: a clear with nothing new reported empties the flags
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && ext_i == '0 && !fault_i) |=> (st_q.flags == '0));

    // R10: a request never appears while the block bit is set
    p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !st_q.ctrl[CW_IRQ_BLOCK]);

endmodule

// File: rtl/tagged_reg_stack.sv
module tagged_reg_stack
    import tagstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    parameter int EXC_N = 6,
    parameter int CW_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 op_i,
    input  logic [$clog2(DEPTH)-1:0]   idx_i,
    input  logic [EXP_W+SIG_W:0]       wdata_i,
    input  logic                       special_i,
    input  logic [EXC_N-1:0]           exc_i,
    input  logic [CW_W-1:0]            cw_i,
    output logic [EXP_W+SIG_W:0]       rdata_o,
    output logic [1:0]                 rtag_o,
    output logic [2*DEPTH-1:0]         tag_word_o,
    output logic [CW_W-1:0]            status_o,
    output logic [CW_W-1:0]            ctrl_o,
    output logic                       irq_o
);

    localparam int DATA_W  = 1 + EXP_W + SIG_W;
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int TOP_LSB = 8;

    op_e              op;
    tag_e             wtag;
    logic [PTR_W-1:0] top;
    logic             fault;
    logic [EXC_N-1:0] flags;

    assign op = op_e'(op_i);

    tagstk_classify #(
        .EXP_W (EXP_W),
        .SIG_W (SIG_W)
    ) u_classify (
        .value_i   (wdata_i),
        .special_i (special_i),
        .tag_o     (wtag)
    );

    tagstk_regs #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .idx_i   (idx_i),
        .wdata_i (wdata_i),
        .wtag_i  (wtag),
        .rdata_o (rdata_o),
        .rtag_o  (rtag_o),
        .tags_o  (tag_word_o),
        .top_o   (top),
        .fault_o (fault)
    );

    tagstk_excp #(
        .EXC_N (EXC_N),
        .CW_W  (CW_W)
    ) u_excp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (op == OP_CLEAR),
        .load_i  (op == OP_LOADCW),
        .cw_i    (cw_i),
        .fault_i (fault),
        .ext_i   (exc_i),
        .flags_o (flags),
        .ctrl_o  (ctrl_o),
        .irq_o   (irq_o)
    );

    always_comb begin
        status_o                    = '0;
        status_o[EXC_N-1:0]         = flags;
        status_o[TOP_LSB +: PTR_W]  = top;
    end

    // R11: the pointer field only moves on push or pop
    p_status_top_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_PUSH && op != OP_POP) |=> $stable(status_o[TOP_LSB +: PTR_W]));

endmodule

// File: tb/tagged_reg_stack_bench.sv
module tagged_reg_stack_bench;

    localparam logic [2:0] C_NOP = 3'd0, C_PUSH = 3'd1, C_POP = 3'd2, C_READ = 3'd3,
                           C_WRITE = 3'd4, C_CLR = 3'd5, C_LDCW = 3'd6;

    localparam logic [79:0] DA = 80'h3FFF_8000_0000_0000_0000; // valid
    localparam logic [79:0] DZ = 80'h8000_0000_0000_0000_0000; // negative zero
    localparam logic [79:0] DB = 80'h7FFF_C000_0000_0000_0000; // pushed as special
    localparam logic [79:0] DC = 80'h4000_0000_0000_0000_1234; // valid

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  idx;
        logic [79:0] data;
        logic        spec;
        logic [5:0]  exc;
        logic [15:0] cw;
        logic [15:0] tw;
        logic [15:0] st;
        logic [79:0] rd;
        logic [1:0]  rt;
        logic        irq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R2 R3: push valid, top 0 -> 7
        '{C_PUSH,  3'd0, DA,    1'b0, 6'h00, 16'h0000, 16'h3FFF, 16'h0700, 80'h0, 2'd3, 1'b0},
        // R3: negative zero tagged zero
        '{C_PUSH,  3'd0, DZ,    1'b0, 6'h00, 16'h0000, 16'h1FFF, 16'h0600, 80'h0, 2'd3, 1'b0},
        // R3: special tag
        '{C_PUSH,  3'd0, DB,    1'b1, 6'h00, 16'h0000, 16'h1BFF, 16'h0500, 80'h0, 2'd3, 1'b0},
        // R5: relative reads
        '{C_READ,  3'd2, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1BFF, 16'h0500, DA,    2'd0, 1'b0},
        '{C_READ,  3'd1, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1BFF, 16'h0500, DZ,    2'd1, 1'b0},
        // R7: read of empty register, masked
        '{C_READ,  3'd3, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1BFF, 16'h0501, DZ,    2'd1, 1'b0},
        // R10: unmask invalid, then block, then clear (R9), then open all
        '{C_LDCW,  3'd0, 80'h0, 1'b0, 6'h00, 16'h003E, 16'h1BFF, 16'h0501, DZ,    2'd1, 1'b1},
        '{C_LDCW,  3'd0, 80'h0, 1'b0, 6'h00, 16'h00BE, 16'h1BFF, 16'h0501, DZ,    2'd1, 1'b0},
        '{C_CLR,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1BFF, 16'h0500, DZ,    2'd1, 1'b0},
        '{C_LDCW,  3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1BFF, 16'h0500, DZ,    2'd1, 1'b0},
        // R8: external zero-divide report
        '{C_NOP,   3'd0, 80'h0, 1'b0, 6'h04, 16'h0000, 16'h1BFF, 16'h0504, DZ,    2'd1, 1'b1},
        // R4: pop special
        '{C_POP,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1FFF, 16'h0604, DB,    2'd2, 1'b1},
        // R6: write into empty register 0 at offset 2
        '{C_WRITE, 3'd2, DC,    1'b0, 6'h00, 16'h0000, 16'h1FFC, 16'h0604, DB,    2'd2, 1'b1},
        '{C_READ,  3'd2, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h1FFC, 16'h0604, DC,    2'd0, 1'b1},
        // R9: clear with same-cycle precision report
        '{C_CLR,   3'd0, 80'h0, 1'b0, 6'h20, 16'h0000, 16'h1FFC, 16'h0620, DC,    2'd0, 1'b1},
        // R4: pops with pointer wrap 7 -> 0
        '{C_POP,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'h3FFC, 16'h0720, DZ,    2'd1, 1'b1},
        '{C_POP,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'hFFFC, 16'h0020, DA,    2'd0, 1'b1},
        '{C_POP,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'hFFFF, 16'h0120, DC,    2'd0, 1'b1},
        // R7: pop of empty stack
        '{C_POP,   3'd0, 80'h0, 1'b0, 6'h00, 16'h0000, 16'hFFFF, 16'h0121, DC,    2'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = C_NOP;
    logic [2:0]  idx_i = '0;
    logic [79:0] wdata_i = '0;
    logic        special_i = 1'b0;
    logic [5:0]  exc_i = '0;
    logic [15:0] cw_i = '0;
    logic [79:0] rdata_o;
    logic [1:0]  rtag_o;
    logic [15:0] tag_word_o;
    logic [15:0] status_o;
    logic [15:0] ctrl_o;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tagged_reg_stack u_tagged_reg_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .idx_i      (idx_i),
        .wdata_i    (wdata_i),
        .special_i  (special_i),
        .exc_i      (exc_i),
        .cw_i       (cw_i),
        .rdata_o    (rdata_o),
        .rtag_o     (rtag_o),
        .tag_word_o (tag_word_o),
        .status_o   (status_o),
        .ctrl_o     (ctrl_o),
        .irq_o      (irq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d,
                         input logic sp, input logic [5:0] ex, input logic [15:0] cw);
        @(negedge clk);
        op_i = op; idx_i = idx; wdata_i = d; special_i = sp; exc_i = ex; cw_i = cw;
        @(posedge clk);
        #1;
        op_i = C_NOP; exc_i = '0; special_i = 1'b0;
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            C_PUSH:  return "R2";
            C_POP:   return "R4";
            C_READ:  return "R5";
            C_WRITE: return "R6";
            C_CLR:   return "R9";
            C_LDCW:  return "R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check_reset();
        chk("R1", "tag word", 80'(tag_word_o), 80'hFFFF);
        chk("R1", "status",   80'(status_o),   80'h0000);
        chk("R1", "control",  80'(ctrl_o),     80'h003F);
        chk("R1", "irq",      80'(irq_o),      80'h0);
        chk("R1", "rdata",    rdata_o,         80'h0);
        chk("R1", "rtag",     80'(rtag_o),     80'h3);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset();
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v].op, VECS[v].idx, VECS[v].data, VECS[v].spec, VECS[v].exc, VECS[v].cw);
            chk("R3",  $sformatf("v%0d tag word", v), 80'(tag_word_o), 80'(VECS[v].tw));
            chk("R11", $sformatf("v%0d status", v),   80'(status_o),   80'(VECS[v].st));
            chk(req_of(VECS[v].op), $sformatf("v%0d rdata", v), rdata_o, VECS[v].rd);
            chk(req_of(VECS[v].op), $sformatf("v%0d rtag", v),  80'(rtag_o), 80'(VECS[v].rt));
            chk("R10", $sformatf("v%0d irq", v),      80'(irq_o),      80'(VECS[v].irq));
        end

        // R2: fill the whole stack from top 1, wrapping through 0
        apply(C_CLR, 3'd0, 80'h0, 1'b0, 6'h00, 16'h0);
        apply(C_PUSH, 3'd0, DA, 1'b0, 6'h00, 16'h0);
        chk("R2", "wrap push status", 80'(status_o), 80'h0000);
        for (int k = 1; k < 8; k++) begin
            apply(C_PUSH, 3'd0, DC, 1'b0, 6'h00, 16'h0);
        end
        chk("R2", "full tag word", 80'(tag_word_o), 80'h0000);
        chk("R2", "full status",   80'(status_o),   80'h0100);

        // R7: push onto a full stack
        apply(C_PUSH, 3'd0, DB, 1'b1, 6'h00, 16'h0);
        chk("R7", "overflow status",   80'(status_o),   80'h0101);
        chk("R7", "overflow tag word", 80'(tag_word_o), 80'h0000);
        apply(C_READ, 3'd0, 80'h0, 1'b0, 6'h00, 16'h0);
        chk("R7", "top value kept", rdata_o, DC);

        // R10: control word load and mask evaluation
        apply(C_LDCW, 3'd0, 80'h0, 1'b0, 6'h00, 16'h1234);
        chk("R10", "control load", 80'(ctrl_o), 80'h1234);
        chk("R10", "irq unmasked", 80'(irq_o),  80'h1);
        apply(C_LDCW, 3'd0, 80'h0, 1'b0, 6'h00, 16'h0035);
        chk("R10", "irq masked", 80'(irq_o), 80'h0);

        // R1: reset in mid run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_reset();
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule